// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Loader

This block is the programming front end of a configurable clock-divider core. A host writes 24-bit words over three slow wires: a serial clock, a data line and a latch-enable strobe. All three wires are brought into the system clock domain through two-flop synchronisers. Their edges are detected there. Each detected serial clock rise shifts the synchronised data bit into a 24-bit shift register, most significant bit first.

A rising edge on the latch-enable strobe commits the word. The two bits received last are the destination code, and the other 22 bits are the payload. The payload is written into one of four holding latches: reference divider, A/B divider, function or initialization. A write to the initialization latch also loads the same payload into the function latch.

The strobe always commits the 24 bits shifted in most recently. If the number of serial clocks since the previous strobe was not exactly 24, a length-error flag is raised. The flag stays raised until the next strobe.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, all four holding latches read zero and `len_err_o` is 0.
- R2: Bits enter most significant first. Of a 24-bit word, the first bit sent lands in payload bit 21 and the 22nd bit sent lands in payload bit 0.
- R3: The last two bits sent form the destination code {first, second}. The codes are 2'b00 reference latch, 2'b01 A/B latch, 2'b10 function latch and 2'b11 initialization latch.
- R4: A commit changes only the addressed latch. All other latches hold their values.
- R5: A commit with code 2'b11 writes the payload into both the initialization latch and the function latch.
- R6: The data level is taken at the serial clock rising edge. Data changes while the serial clock is high, or between rising edges, have no effect.
- R7: Latches change only on a latch-enable rising edge. They are updated within 3 system clocks of that edge. Shifting without a strobe leaves every latch unchanged.
- R8: A strobe after a count of serial clocks other than 24 still commits the last 24 bits shifted and sets `len_err_o` to 1. A strobe after exactly 24 clocks clears it. The flag changes only on a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| sle_i | input | 1 | Latch-enable strobe, asynchronous |
| ref_lat_o | output | 22 | Reference divider latch payload |
| ab_lat_o | output | 22 | A/B divider latch payload |
| fn_lat_o | output | 22 | Function latch payload |
| init_lat_o | output | 22 | Initialization latch payload |
| len_err_o | output | 1 | Bit-count mismatch at the last strobe |

## Verification
Random payloads are sent under each of the four destination codes, so that a code decoded to the wrong latch shows up as a change in a latch that should hold. A single-bit-set word separates MSB-first from LSB-first ordering. A word whose data line toggles while the serial clock is high tells rising-edge sampling apart from level or falling-edge capture. Strobe-less shifting, then short, long and exact-length words, exercise the commit rule and the setting and clearing of the length flag.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int CTRL_W = 2;
  typedef enum logic [CTRL_W-1:0] {
    DST_REF  = 2'b00,
    DST_AB   = 2'b01,
    DST_FN   = 2'b10,
    DST_INIT = 2'b11
  } dst_e;
endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], async_i[g]};
        prev_q <= sync_q[STAGES-1];
      end
    end
    assign lvl_o[g]  = sync_q[STAGES-1];
    assign rise_o[g] = sync_q[STAGES-1] & ~prev_q;
  end
endmodule

// File: rtl/cfg_shift_in.sv
module cfg_shift_in #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
    end else if (shift_i) begin
      word_o <= {word_o[WORD_W-2:0], bit_i};
    end
  end

  // counts serial clocks since the last strobe, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (shift_i && cnt_o != CNT_MAX) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import cfg_loader_pkg::*;
#(
  parameter int WORD_W = 24,
  localparam int PAY_W = WORD_W - CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              len_ok_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [PAY_W-1:0]  ref_o,
  output logic [PAY_W-1:0]  ab_o,
  output logic [PAY_W-1:0]  fn_o,
  output logic [PAY_W-1:0]  init_o,
  output logic              len_err_o
);
  dst_e             dst;
  logic [PAY_W-1:0] pay;

  assign dst = dst_e'(word_i[CTRL_W-1:0]);
  assign pay = word_i[WORD_W-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o     <= '0;
      ab_o      <= '0;
      fn_o      <= '0;
      init_o    <= '0;
      len_err_o <= 1'b0;
    end else if (load_i) begin
      len_err_o <= !len_ok_i;
      unique case (dst)
        DST_REF:  ref_o <= pay;
        DST_AB:   ab_o  <= pay;
        DST_FN:   fn_o  <= pay;
        DST_INIT: begin
          init_o <= pay;
          fn_o   <= pay;  // init write also refreshes function latch
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     sclk_i,
  input  logic                                     sdata_i,
  input  logic                                     sle_i,
  output logic [WORD_W-cfg_loader_pkg::CTRL_W-1:0] ref_lat_o,
  output logic [WORD_W-cfg_loader_pkg::CTRL_W-1:0] ab_lat_o,
  output logic [WORD_W-cfg_loader_pkg::CTRL_W-1:0] fn_lat_o,
  output logic [WORD_W-cfg_loader_pkg::CTRL_W-1:0] init_lat_o,
  output logic                                     len_err_o
);
  localparam int CNT_W = $clog2(WORD_W + 1) + 1;
  localparam int SCLK = 0, SDAT = 1, SLE = 2;

  logic [2:0]        lvl, rise;
  logic              sclk_rise, le_rise, data_lvl;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  cnt;
  logic              unused_sync;

  cfg_edge_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .async_i({sle_i, sdata_i, sclk_i}),
    .lvl_o(lvl), .rise_o(rise)
  );

  assign sclk_rise   = rise[SCLK];
  assign le_rise     = rise[SLE];
  assign data_lvl    = lvl[SDAT];
  assign unused_sync = ^{lvl[SCLK], lvl[SLE], rise[SDAT]};

  cfg_shift_in #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk_i, .rst_ni,
    .shift_i(sclk_rise), .bit_i(data_lvl), .clr_i(le_rise),
    .word_o(word), .cnt_o(cnt)
  );

  cfg_latch_bank #(.WORD_W(WORD_W)) u_bank (
    .clk_i, .rst_ni,
    .load_i(le_rise),
    .len_ok_i(cnt == CNT_W'(WORD_W)),
    .word_i(word),
    .ref_o(ref_lat_o), .ab_o(ab_lat_o), .fn_o(fn_lat_o), .init_o(init_lat_o),
    .len_err_o(len_err_o)
  );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int PAY_W = 22
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             le_rise_i,
  input logic [PAY_W-1:0] ref_i,
  input logic [PAY_W-1:0] ab_i,
  input logic [PAY_W-1:0] fn_i,
  input logic [PAY_W-1:0] init_i,
  input logic             err_i
);
  assert_hold_no_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_rise_i |=> ($stable(ref_i) && $stable(ab_i) && $stable(fn_i) && $stable(init_i)));

  assert_flag_on_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_rise_i |=> $stable(err_i));

  assert_init_mirrors_fn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(init_i) |-> (fn_i == init_i));

  assert_ref_alone_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ref_i) |-> ($stable(ab_i) && $stable(fn_i) && $stable(init_i)));

  assert_ab_alone_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ab_i) |-> ($stable(ref_i) && $stable(fn_i) && $stable(init_i)));

  assert_fn_alone_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(fn_i) && $stable(init_i)) |-> ($stable(ref_i) && $stable(ab_i)));
endmodule

bind cfg_serial_loader cfg_loader_chk #(.PAY_W(WORD_W - cfg_loader_pkg::CTRL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .le_rise_i(le_rise),
  .ref_i(ref_lat_o), .ab_i(ab_lat_o), .fn_i(fn_lat_o), .init_i(init_lat_o),
  .err_i(len_err_o)
);

// File: tb/sim_cfg_serial_loader.sv
`timescale 1ns/1ps
module sim_cfg_serial_loader;
  localparam int PAY_W = 22;
  localparam int HOLD  = 4;

  typedef struct packed {
    logic [PAY_W-1:0] r, a, f, i;
    logic             e;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
  logic [PAY_W-1:0] ref_o, ab_o, fn_o, init_o;
  logic err_o;

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];

  exp_t        m;
  logic [23:0] m_sr = '0;
  int          m_cnt = 0;

  always #4 clk = ~clk;

  cfg_serial_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sle_i(sle),
    .ref_lat_o(ref_o), .ab_lat_o(ab_o), .fn_lat_o(fn_o), .init_lat_o(init_o),
    .len_err_o(err_o)
  );

  task automatic chk(input string tag, input string fld, input logic [PAY_W-1:0] act,
                     input logic [PAY_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against outputs
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  x;
      string t;
      x = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, "ref", ref_o, x.r);
      chk(t, "ab", ab_o, x.a);
      chk(t, "fn", fn_o, x.f);
      chk(t, "init", init_o, x.i);
      chk(t, "len_err", PAY_W'(err_o), PAY_W'(x.e));
    end
  end

  task automatic send(input logic [31:0] w, input int n, input bit do_le,
                      input bit glitch, input string tag);
    for (int k = n - 1; k >= 0; k--) begin
      sdata = w[k];
      repeat (HOLD) @(posedge clk);
      sclk = 1'b1;
      m_sr = {m_sr[22:0], w[k]};
      m_cnt++;
      repeat (HOLD) @(posedge clk);
      if (glitch) sdata = ~w[k];  // R6: toggle while clock high
      repeat (HOLD) @(posedge clk);
      sclk = 1'b0;
      if (glitch) begin
        repeat (HOLD) @(posedge clk);
        sdata = w[k];
      end
    end
    repeat (HOLD) @(posedge clk);
    if (do_le) begin
      sle = 1'b1;
      repeat (HOLD) @(posedge clk);
      sle = 1'b0;
      m.e = (m_cnt != 24);
      m_cnt = 0;
      case (m_sr[1:0])
        2'b00: m.r = m_sr[23:2];
        2'b01: m.a = m_sr[23:2];
        2'b10: m.f = m_sr[23:2];
        default: begin m.i = m_sr[23:2]; m.f = m_sr[23:2]; end
      endcase
    end
    repeat (8) @(posedge clk);
    exp_q.push_back(m);
    tag_q.push_back(tag);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    m = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    exp_q.push_back(m); tag_q.push_back("R1 reset");
    repeat (2) @(posedge clk);

    // R3/R4: random payloads for each destination code
    for (int rep = 0; rep < 3; rep++)
      for (int c = 0; c < 4; c++)
        send({8'h0, 22'($urandom()), 2'(c)}, 24, 1'b1, 1'b0, "R3/R4 rand");

    // R2: single high bit must land in payload MSB
    send({8'h0, 22'h200000, 2'b01}, 24, 1'b1, 1'b0, "R2 msb");
    send({8'h0, 22'h000001, 2'b00}, 24, 1'b1, 1'b0, "R2 lsb");

    // R5: init write mirrors into function latch
    send({8'h0, 22'h15A5A5, 2'b11}, 24, 1'b1, 1'b0, "R5 init");

    // R6: data toggling while clock high must be ignored
    send({8'h0, 22'h2C3E1F, 2'b10}, 24, 1'b1, 1'b1, "R6 glitch");

    // R7: shifting without strobe leaves latches unchanged
    send({8'h0, 22'h3FFFFF, 2'b00}, 24, 1'b0, 1'b0, "R7 no strobe");

    // R8: short, long, then exact word
    send({12'h0, 18'h2AAAA, 2'b01}, 20, 1'b1, 1'b0, "R8 short");
    send({4'h0, 26'h1234567, 2'b00}, 28, 1'b1, 1'b0, "R8 long");
    send({8'h0, 22'h0F0F0F, 2'b10}, 24, 1'b1, 1'b0, "R8 exact");

    repeat (4) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule